// File: doc/BRIEF.md
# Line-Cycle Energy Accumulator Bank

This block keeps nine signed energy accumulators: three phases for each of three energy kinds (active, reactive, apparent). Every cycle with `inc_valid` high, each accumulator lane receives its own signed increment from an upstream power computation. Each kind has its own mode bit. In free-running mode the increments are added directly into the readable register. In line-cycle mode the increments go into a hidden running sum. The running sum is published only when a window closes. A window closes after a programmed number of zero-crossing strobes from a chosen subset of phases.

Software reaches the bank through a simple register port. It reads accumulators, config and status, and it writes config and status. An optional clear-on-read mode empties an accumulator in the same access that reads it. Each kind runs a small state machine with three states. **FREE** means free-running accumulation. **ARM** is a one-cycle restart after a config change. **COLLECT** means line-cycle accumulation. The transitions are named as follows:
- *FREE→ARM* and *COLLECT→ARM* happen on a restart.
- *ARM→ARM* happens when a restart repeats.
- *ARM→FREE* or *ARM→COLLECT* follows the new mode bit.
- *COLLECT→COLLECT* happens on each window close.

Top module: `energy_bank`

## Requirements
- R1: After reset the accumulators and status read 0 and the config reads 0x78. The config layout is: bits[2:0] are the line-cycle mode bits for active/reactive/apparent, bits[5:3] select phases A/B/C for crossing counts, bit 6 enables clear-on-read, and bit 7 is reserved. The address map is: 0–8 are accumulators at kind*3+phase, 9 is config, 10 is status.
- R2: In free-running mode each valid increment is added to the accumulator, saturating at the signed 32-bit maximum and minimum.
- R3: In line-cycle mode each strobe on a selected phase adds one to the kind's crossing count, and simultaneous strobes add together. The window closes in the cycle where the total reaches the target and is at least 1, so a target of 0 acts as 1.
- R4: On a window close, each lane of the kind publishes its running sum including that cycle's increment, and the sum and count restart from 0. `win_done[k]` is high in the next cycle for one cycle per close. Between closes the published value holds.
- R5: A close sets status bit k. Writing 1 to a status bit clears it, and a set in the same cycle wins.
- R6: With clear-on-read enabled, reading an accumulator returns its value and empties it. An increment in that same cycle becomes the new content.
- R7: With clear-on-read disabled, reads leave accumulators unchanged.
- R8: Config bit 7 always reads 0 and writing it has no effect.
- R9: A config write that changes a kind's mode bit, or changes the phase select, puts that kind through one ARM cycle. The ARM cycle zeroes its count and running sums, and increments and strobes in that cycle are discarded.
- R10: `reg_rdata` takes the addressed value one cycle after `reg_rd`, as it stood in the read cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inc_valid | input | 1 | Increments are valid this cycle |
| inc_data | input | 216 | Nine 24-bit signed increments, lane kind*3+phase at bits lane*24 |
| zx | input | 3 | Zero-crossing strobes for phases A, B, C |
| cycle_target | input | 16 | Crossing count that closes a window |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| win_done | output | 3 | One-cycle window-close pulse per kind |

## Verification
The timing of each result is as follows:
- An increment, a read clear or a window close shows in the accumulator from the next cycle.
- `win_done` and the status bit are set in the cycle after the input cycle that brings the count to the target.
- Read data appears one cycle after the strobe.
- A config write takes effect with a single ARM cycle after it.

The bench advances its reference model once per clock, using the same pre-edge inputs the design sees. It then compares `win_done` in every cycle and read data exactly one cycle after each read, with samples taken 1 ns after the edge.

// File: rtl/energy_bank_pkg.sv
package energy_bank_pkg;
    localparam int N_KIND = 3;

    typedef enum logic [1:0] {
        ST_FREE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_COLLECT = 2'd2
    } win_state_t;
endpackage

// File: rtl/eb_acc_lane.sv
module eb_acc_lane #(
    parameter int ACC_W = 32,
    parameter int INC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             free_en,
    input  logic             collect_en,
    input  logic             arm,
    input  logic             close,
    input  logic             inc_valid,
    input  logic [INC_W-1:0] inc_data,
    input  logic             clr_rd,
    output logic [ACC_W-1:0] acc_q
);
    logic [ACC_W-1:0] acc_d, sum_q, sum_d, base;
    logic [INC_W-1:0] incr;

    function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                                 input logic [INC_W-1:0] b);
        logic [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {{(ACC_W+1-INC_W){b[INC_W-1]}}, b};
        if (s[ACC_W] != s[ACC_W-1])
            return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        return s[ACC_W-1:0];
    endfunction

    always_comb begin
        incr  = inc_valid ? inc_data : '0;
        base  = clr_rd ? '0 : acc_q;
        acc_d = base;
        sum_d = sum_q;
        if (collect_en && close) begin
            acc_d = sat_add(sum_q, incr);
            sum_d = '0;
        end else if (collect_en) begin
            sum_d = sat_add(sum_q, incr);
        end else begin
            sum_d = '0;
            if (free_en && inc_valid) acc_d = sat_add(base, inc_data);
        end
        if (arm) sum_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            sum_q <= '0;
        end else begin
            acc_q <= acc_d;
            sum_q <= sum_d;
        end
    end

    a_r9_arm_sum_zero: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> sum_q == '0);
    a_r2_free_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (free_en && !inc_valid && !clr_rd) |=> $stable(acc_q));
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !inc_valid && !(collect_en && close)) |=> acc_q == '0);
endmodule

// File: rtl/eb_zx_window.sv
module eb_zx_window
    import energy_bank_pkg::*;
#(
    parameter int N_PH  = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_mode,
    input  logic             restart,
    input  logic [N_PH-1:0]  zx,
    input  logic [N_PH-1:0]  zx_sel,
    input  logic [CNT_W-1:0] target,
    output logic             free_en,
    output logic             collect_en,
    output logic             arm,
    output logic             close
);
    localparam int ADD_W = $clog2(N_PH + 1);
    localparam int CW    = CNT_W + ADD_W;

    win_state_t      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_sum;
    logic [ADD_W-1:0] hits;
    logic            close_w;

    always_comb begin
        hits    = ADD_W'($countones(zx & zx_sel));
        cnt_sum = cnt_q + CW'(hits);
        close_w = (state_q == ST_COLLECT) && (cnt_sum != '0) && (cnt_sum >= CW'(target));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:    if (restart) state_d = ST_ARM;
            ST_ARM:     if (!restart) state_d = line_mode ? ST_COLLECT : ST_FREE;
            ST_COLLECT: if (restart) state_d = ST_ARM;
            default:    state_d = ST_ARM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        free_en    = (state_q == ST_FREE);
        arm        = (state_q == ST_ARM);
        collect_en = (state_q == ST_COLLECT);
        close      = close_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || state_q != ST_COLLECT || close_w)
            cnt_q <= '0;
        else
            cnt_q <= cnt_sum;
    end

    a_r9_arm_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |-> cnt_q == '0);
    a_r4_close_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> cnt_q == '0);
    a_r3_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (collect_en && !close && !restart) |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/eb_regif.sv
module eb_regif
    import energy_bank_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int N_PH   = 3,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [ACC_W-1:0]          reg_wdata,
    input  logic [N_KIND*N_PH*ACC_W-1:0] acc_flat,
    input  logic [N_KIND-1:0]         done,
    output logic [ACC_W-1:0]          reg_rdata,
    output logic [N_KIND-1:0]         line_mode,
    output logic [N_PH-1:0]           zx_sel,
    output logic [N_KIND-1:0]         restart,
    output logic [N_KIND*N_PH-1:0]    clr_lane
);
    localparam int N_LANE = N_KIND * N_PH;
    localparam int RC_BIT = N_KIND + N_PH;
    localparam int RSV_BIT = RC_BIT + 1;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = ADDR_W'(N_LANE);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(N_LANE + 1);

    logic [N_KIND-1:0] mode_q, stat_q, w1c;
    logic [N_PH-1:0]   sel_q;
    logic              rdclr_q;
    logic              cfg_wr, stat_wr;
    logic [ACC_W-1:0]  rd_val;

    always_comb begin
        cfg_wr  = reg_wr && (reg_addr == ADDR_CFG);
        stat_wr = reg_wr && (reg_addr == ADDR_STAT);
        w1c     = stat_wr ? reg_wdata[N_KIND-1:0] : '0;
        for (int k = 0; k < N_KIND; k++)
            restart[k] = cfg_wr && ((reg_wdata[k] != mode_q[k]) ||
                                    (reg_wdata[N_KIND +: N_PH] != sel_q));
        for (int i = 0; i < N_LANE; i++)
            clr_lane[i] = reg_rd && rdclr_q && (reg_addr == ADDR_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            sel_q   <= '1;
            rdclr_q <= 1'b1;
            stat_q  <= '0;
        end else begin
            if (cfg_wr) begin
                mode_q  <= reg_wdata[N_KIND-1:0];
                sel_q   <= reg_wdata[N_KIND +: N_PH];
                rdclr_q <= reg_wdata[RC_BIT];
            end
            stat_q <= (stat_q & ~w1c) | done;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_LANE; i++)
            if (reg_addr == ADDR_W'(i)) rd_val = acc_flat[i*ACC_W +: ACC_W];
        if (reg_addr == ADDR_CFG)  rd_val[RC_BIT:0]   = {rdclr_q, sel_q, mode_q};
        if (reg_addr == ADDR_STAT) rd_val[N_KIND-1:0] = stat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    always_comb begin
        line_mode = mode_q;
        zx_sel    = sel_q;
    end

    a_r5_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> (stat_q & $past(done)) == $past(done));
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_CFG) |=> reg_rdata[RSV_BIT] == 1'b0);
    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/energy_bank.sv
module energy_bank
    import energy_bank_pkg::*;
#(
    parameter int N_PH   = 3,
    parameter int ACC_W  = 32,
    parameter int INC_W  = 24,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         inc_valid,
    input  logic [N_KIND*N_PH*INC_W-1:0] inc_data,
    input  logic [N_PH-1:0]              zx,
    input  logic [CNT_W-1:0]             cycle_target,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [ACC_W-1:0]             reg_wdata,
    output logic [ACC_W-1:0]             reg_rdata,
    output logic [N_KIND-1:0]            win_done
);
    localparam int N_LANE = N_KIND * N_PH;

    logic [N_LANE*ACC_W-1:0] acc_flat;
    logic [N_KIND-1:0] line_mode, restart, free_en, collect_en, arm, close;
    logic [N_PH-1:0]   zx_sel;
    logic [N_LANE-1:0] clr_lane;

    eb_regif #(.ACC_W(ACC_W), .N_PH(N_PH), .ADDR_W(ADDR_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .acc_flat(acc_flat),
        .done(close), .reg_rdata(reg_rdata), .line_mode(line_mode),
        .zx_sel(zx_sel), .restart(restart), .clr_lane(clr_lane)
    );

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        eb_zx_window #(.N_PH(N_PH), .CNT_W(CNT_W)) u_win (
            .clk(clk), .rst_n(rst_n), .line_mode(line_mode[k]),
            .restart(restart[k]), .zx(zx), .zx_sel(zx_sel),
            .target(cycle_target), .free_en(free_en[k]),
            .collect_en(collect_en[k]), .arm(arm[k]), .close(close[k])
        );
        for (genvar p = 0; p < N_PH; p++) begin : g_ph
            localparam int LI = k * N_PH + p;
            eb_acc_lane #(.ACC_W(ACC_W), .INC_W(INC_W)) u_lane (
                .clk(clk), .rst_n(rst_n), .free_en(free_en[k]),
                .collect_en(collect_en[k]), .arm(arm[k]), .close(close[k]),
                .inc_valid(inc_valid), .inc_data(inc_data[LI*INC_W +: INC_W]),
                .clr_rd(clr_lane[LI]), .acc_q(acc_flat[LI*ACC_W +: ACC_W])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_done <= '0;
        else        win_done <= close;
    end

    a_r4_done_needs_collect: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done != '0) |-> ($past(collect_en) & win_done) == win_done);
endmodule

// File: tb/energy_bank_tb_top.sv
`timescale 1ns/100ps
module energy_bank_tb_top;
    localparam int INC_W = 24, ACC_W = 32, CNT_W = 16, NL = 9;
    localparam longint MAXV = (longint'(1) <<< 31) - 1;
    localparam longint MINV = -(longint'(1) <<< 31);

    logic clk = 1'b0, rst_n = 1'b0, inc_valid = 1'b0;
    logic [NL*INC_W-1:0] inc_data;
    logic [2:0] zx = '0;
    logic [CNT_W-1:0] cycle_target = 16'd4;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [ACC_W-1:0] reg_wdata = '0;
    logic [ACC_W-1:0] reg_rdata;
    logic [2:0] win_done;

    int inc_v[NL];
    int n_chk = 0, n_fail = 0;

    longint m_acc[NL], m_sum[NL];
    int m_cnt[3];
    bit m_arm[3];
    logic [6:0] m_cfg = 7'h78;
    logic [2:0] m_stat = '0, m_done = '0;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < NL; i++) inc_data[i*INC_W +: INC_W] = inc_v[i][INC_W-1:0];

    energy_bank dut_i (
        .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_data(inc_data),
        .zx(zx), .cycle_target(cycle_target), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .win_done(win_done)
    );

    function automatic longint sat(longint v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge(output longint rv);
        logic [6:0] nc;
        rv = 0;
        if (reg_rd) begin
            if (reg_addr < NL)       rv = m_acc[reg_addr];
            else if (reg_addr == 9)  rv = {25'd0, m_cfg};
            else if (reg_addr == 10) rv = {29'd0, m_stat};
        end
        m_done = '0;
        for (int k = 0; k < 3; k++) begin
            if (m_arm[k]) begin
                for (int p = 0; p < 3; p++) begin
                    if (reg_rd && m_cfg[6] && reg_addr == k*3+p) m_acc[k*3+p] = 0;
                    m_sum[k*3+p] = 0;
                end
                m_cnt[k] = 0;
                m_arm[k] = 0;
            end else if (!m_cfg[k]) begin
                for (int p = 0; p < 3; p++) begin
                    longint b;
                    b = (reg_rd && m_cfg[6] && reg_addr == k*3+p) ? 0 : m_acc[k*3+p];
                    m_acc[k*3+p] = inc_valid ? sat(b + inc_v[k*3+p]) : b;
                    m_sum[k*3+p] = 0;
                end
            end else begin
                int c;
                c = m_cnt[k] + $countones(zx & m_cfg[5:3]);
                m_done[k] = (c != 0) && (c >= int'(cycle_target));
                for (int p = 0; p < 3; p++) begin
                    longint s;
                    s = inc_valid ? sat(m_sum[k*3+p] + inc_v[k*3+p]) : m_sum[k*3+p];
                    if (m_done[k]) begin
                        m_acc[k*3+p] = s;
                        m_sum[k*3+p] = 0;
                    end else begin
                        if (reg_rd && m_cfg[6] && reg_addr == k*3+p) m_acc[k*3+p] = 0;
                        m_sum[k*3+p] = s;
                    end
                end
                m_cnt[k] = m_done[k] ? 0 : c;
            end
        end
        m_stat = (m_stat & ~((reg_wr && reg_addr == 10) ? reg_wdata[2:0] : 3'b0)) | m_done;
        if (reg_wr && reg_addr == 9) begin
            nc = reg_wdata[6:0];
            for (int k = 0; k < 3; k++)
                if (nc[k] != m_cfg[k] || nc[5:3] != m_cfg[5:3]) m_arm[k] = 1;
            m_cfg = nc;
        end
    endtask

    task automatic step(string req);
        longint rv;
        bit was_rd;
        was_rd = reg_rd;
        model_edge(rv);
        @(posedge clk);
        #1;
        chk("R4 win_done", longint'(win_done), longint'(m_done));
        if (was_rd) chk(req, longint'($signed(reg_rdata)), rv);
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, string req);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(req);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, string req);
        reg_rd = 1'b1; reg_addr = a;
        step(req);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin inc_v[i] = 0; m_acc[i] = 0; m_sum[i] = 0; end
        for (int k = 0; k < 3; k++) begin m_cnt[k] = 0; m_arm[k] = 0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(9, "R1 config reset");
        rd(10, "R1 status reset");
        rd(0, "R1 accumulator reset");
        rd(14, "R10 unmapped reads zero");

        for (int i = 0; i < NL; i++) inc_v[i] = (i + 1) * 100 - 300;
        inc_valid = 1'b1;
        idle(5, "R2");
        inc_valid = 1'b0;
        rd(0, "R2 free accumulate negative");
        rd(0, "R6 cleared after read");
        rd(8, "R2 free accumulate positive");
        inc_valid = 1'b1;
        rd(3, "R6 read with increment");
        inc_valid = 1'b0;
        rd(3, "R6 increment kept");

        wr(9, 32'hB8, "R8 write reserved");
        rd(9, "R8 reserved reads zero");
        rd(4, "R7 read without clear");
        rd(4, "R7 value unchanged");

        wr(9, 32'h39, "R9 enter line mode");
        cycle_target = 16'd4;
        inc_valid = 1'b1;
        for (int c = 0; c < 24; c++) begin
            inc_v[c % 3] = c * 7 - 40;
            zx = (c % 3 == 0) ? 3'b001 : ((c % 5 == 0) ? 3'b110 : 3'b000);
            if (c % 4 == 0) begin reg_rd = 1'b1; reg_addr = 4'(c % 3); end
            step("R3 line window read");
            reg_rd = 1'b0;
        end
        zx = '0;
        rd(10, "R5 sticky status");
        wr(10, 32'h1, "R5 write one to clear");
        rd(10, "R5 status cleared");

        wr(9, 32'h09, "R9 select phase A only");
        zx = 3'b110;
        idle(6, "R9 unselected phases ignored");
        zx = 3'b001;
        idle(5, "R3 selected phase closes");
        zx = '0;
        rd(0, "R4 published sum");
        wr(9, 32'h0B, "R9 second kind to line mode");
        idle(2, "R9");
        zx = 3'b001;
        idle(4, "R4 both kinds close");
        zx = '0;
        rd(3, "R4 reactive published");
        cycle_target = 16'd0;
        idle(3, "R3 target zero no crossings");
        zx = 3'b001;
        idle(2, "R3 target zero acts as one");
        zx = '0;
        rd(10, "R5 status after closes");

        wr(9, 32'h78, "R9 back to free mode");
        for (int i = 0; i < NL; i++) inc_v[i] = 0;
        inc_v[4] = 8388607;
        inc_v[5] = -8388608;
        idle(2, "R2");
        idle(260, "R2 saturating run");
        inc_valid = 1'b0;
        rd(4, "R2 saturate at max");
        rd(5, "R2 saturate at min");
        rd(4, "R6 cleared after saturation");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule